// File: doc/BRIEF.md
# Program Fetch Region Router with Wait States

This block sits between a processor's fetch stage and its three program stores. It takes a 16-bit fetch address and sorts it into one of three regions. On-chip ROM sits at the bottom of the space and on-chip RAM at the top. Off-chip memory fills the gap between them. Two 3-bit size codes set how large each on-chip region is, and each code has a flag that can remove its region. The block returns the byte from the selected store and raises a one-cycle completion pulse. It also drives the strobes each store needs.

On-chip accesses finish in the cycle they are requested, with no wait states. An off-chip access is accepted in its request cycle and then holds the off-chip read or write strobe high. It finishes once a programmed number of wait cycles has elapsed and the external ready line is high. A slow memory or a dynamic memory controller can therefore stretch the access one cycle at a time. Program memory can also be written. A write into the RAM region pulses an internal write enable. A write into the off-chip region uses the off-chip write strobe. A write into the ROM region completes and changes nothing.

Top module: `prog_fetch_router`

## Requirements
- R1: With size code n, the ROM region covers addresses 0 up to 2^(n+7)−1. A request there raises `done_o` in the same cycle, and `rdata_o` equals `rom_rdata_i`.
- R2: With size code n, the RAM region covers addresses 65536−2^(n+7) up to FFFFh. A request there that is outside the ROM region raises `done_o` in the same cycle, and `rdata_o` equals `ram_rdata_i`.
- R3: A request outside both on-chip regions is off-chip. `done_o` stays low in its request cycle. From the next cycle, `ext_rd_o` (read) or `ext_wr_o` (write) is held high up to and including its `done_o` cycle, and drops in the cycle after. `rdata_o` equals `ext_rdata_i` when `done_o` is high.
- R4: For an off-chip access with wait count W (`wait_i` sampled in the request cycle), `done_o` is not raised before strobe cycle W+1. With `ready_i` high, it is raised exactly in strobe cycle W+1.
- R5: Once the wait count has expired, each strobe cycle with `ready_i` low delays `done_o`. `ready_i` during the counting cycles has no effect. `done_o` is a single-cycle pulse per access.
- R6: A region flag (`rom_off_i` or `ram_off_i`) set together with size code 0 removes that region, and its addresses become off-chip. When the size code is not 0, the flag has no effect.
- R7: A write request (`we_i`=1) into the RAM region raises `ram_we_o` in the same cycle as `done_o`. An off-chip write raises `ext_wr_o` and never `ext_rd_o`. A write into the ROM region completes with no write strobe.
- R8: Requests that arrive while an off-chip access is in progress are ignored. `mem_addr_o` and `wdata_o` keep the accepted access's values, no `ram_we_o` is raised, and no extra `done_o` appears.
- R9: During reset and after it, no strobe and no `done_o` are raised, even with `req_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = fetch/read |
| addr_i | input | 16 | Program address |
| wdata_i | input | 8 | Write data |
| rom_code_i | input | 3 | ROM size code |
| rom_off_i | input | 1 | ROM absent when code is 0 |
| ram_code_i | input | 3 | RAM size code |
| ram_off_i | input | 1 | RAM absent when code is 0 |
| wait_i | input | 3 | Off-chip wait count |
| ready_i | input | 1 | Off-chip ready |
| rom_rdata_i | input | 8 | Data from on-chip ROM |
| ram_rdata_i | input | 8 | Data from on-chip RAM |
| ext_rdata_i | input | 8 | Data from off-chip memory |
| mem_addr_o | output | 16 | Address to all stores |
| wdata_o | output | 8 | Write data to stores |
| rdata_o | output | 8 | Selected read data |
| done_o | output | 1 | Access complete, one cycle |
| ram_we_o | output | 1 | On-chip RAM write enable |
| ext_rd_o | output | 1 | Off-chip read strobe |
| ext_wr_o | output | 1 | Off-chip write strobe |

## Verification
Two things can fall in the same cycle. One is the end of the wait count. The other is a change on the ready line, or a new request that arrives while the off-chip access is still active. The bench provokes these cases by drawing a random point where ready goes high. That point can come before, at, or after the wait expiry. In the first strobe cycle the bench also drives an overlapping request, sometimes a RAM write. It then judges three things: the strobe cycle in which `done_o` appears, which must be one past the larger of the wait count and the ready-low span; that the held address is unchanged; and that no stray `ram_we_o` or second completion appears.

// File: rtl/pfr_pkg.sv
package pfr_pkg;
  typedef enum logic [1:0] {
    RG_ROM = 2'd0,
    RG_RAM = 2'd1,
    RG_EXT = 2'd2
  } region_t;
endpackage

// File: rtl/pfr_rst_sync.sv
module pfr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/pfr_region_dec.sv
module pfr_region_dec
  import pfr_pkg::*;
#(
  parameter int AW       = 16,
  parameter int CW       = 3,
  parameter int BASE_LOG = 7
) (
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] rom_code_i,
  input  logic          rom_off_i,
  input  logic [CW-1:0] ram_code_i,
  input  logic          ram_off_i,
  output region_t       region_o
);
  localparam int SW = AW + 1;

  logic [SW-1:0] rom_size, ram_size, ram_base, addr_x;
  logic rom_present, ram_present, rom_hit, ram_hit;

  always_comb begin
    rom_size    = SW'(1) << (int'(rom_code_i) + BASE_LOG);
    ram_size    = SW'(1) << (int'(ram_code_i) + BASE_LOG);
    ram_base    = (SW'(1) << AW) - ram_size;
    addr_x      = {1'b0, addr_i};
    rom_present = !(rom_off_i && (rom_code_i == '0));
    ram_present = !(ram_off_i && (ram_code_i == '0));
    rom_hit     = rom_present && (addr_x < rom_size);
    ram_hit     = ram_present && (addr_x >= ram_base);
    // ROM wins when both regions claim an address
    if (rom_hit)      region_o = RG_ROM;
    else if (ram_hit) region_o = RG_RAM;
    else              region_o = RG_EXT;
  end
endmodule

// File: rtl/pfr_wait_seq.sv
module pfr_wait_seq #(
  parameter int WW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [WW-1:0] wait_i,
  input  logic          ready_i,
  output logic          busy_o,
  output logic          fin_o
);
  logic          busy_q, busy_d;
  logic [WW-1:0] cnt_q, cnt_d;
  logic          en;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    en     = 1'b0;
    if (!busy_q) begin
      if (start_i) begin
        busy_d = 1'b1;
        cnt_d  = wait_i;
        en     = 1'b1;
      end
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
      en    = 1'b1;
    end else if (ready_i) begin
      busy_d = 1'b0;
      en     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;
  assign fin_o  = busy_q && (cnt_q == '0) && ready_i;
endmodule

// File: rtl/prog_fetch_router.sv
module prog_fetch_router
  import pfr_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int CW       = 3,
  parameter int WW       = 3,
  parameter int BASE_LOG = 7,
  parameter int SYNC_STG = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [CW-1:0] rom_code_i,
  input  logic          rom_off_i,
  input  logic [CW-1:0] ram_code_i,
  input  logic          ram_off_i,
  input  logic [WW-1:0] wait_i,
  input  logic          ready_i,
  input  logic [DW-1:0] rom_rdata_i,
  input  logic [DW-1:0] ram_rdata_i,
  input  logic [DW-1:0] ext_rdata_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rdata_o,
  output logic          done_o,
  output logic          ram_we_o,
  output logic          ext_rd_o,
  output logic          ext_wr_o
);
  logic          srst_n;
  region_t       region;
  logic          busy, fin, accept, accept_ext;
  logic [AW-1:0] lat_addr_q;
  logic [DW-1:0] lat_wdata_q;
  logic          lat_we_q;

  pfr_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk      (clk),
    .rst_n    (rst_n),
    .srst_n_o (srst_n)
  );

  pfr_region_dec #(.AW(AW), .CW(CW), .BASE_LOG(BASE_LOG)) u_dec (
    .addr_i     (addr_i),
    .rom_code_i (rom_code_i),
    .rom_off_i  (rom_off_i),
    .ram_code_i (ram_code_i),
    .ram_off_i  (ram_off_i),
    .region_o   (region)
  );

  assign accept     = req_i && !busy && srst_n;
  assign accept_ext = accept && (region == RG_EXT);

  pfr_wait_seq #(.WW(WW)) u_wait (
    .clk     (clk),
    .rst_n   (srst_n),
    .start_i (accept_ext),
    .wait_i  (wait_i),
    .ready_i (ready_i),
    .busy_o  (busy),
    .fin_o   (fin)
  );

  // capture of the off-chip access, enabled only on acceptance
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      lat_addr_q  <= '0;
      lat_wdata_q <= '0;
      lat_we_q    <= 1'b0;
    end else if (accept_ext) begin
      lat_addr_q  <= addr_i;
      lat_wdata_q <= wdata_i;
      lat_we_q    <= we_i;
    end
  end

  always_comb begin
    mem_addr_o = busy ? lat_addr_q  : addr_i;
    wdata_o    = busy ? lat_wdata_q : wdata_i;
    ext_rd_o   = busy && !lat_we_q;
    ext_wr_o   = busy &&  lat_we_q;
    ram_we_o   = accept && we_i && (region == RG_RAM);
    done_o     = fin || (accept && (region != RG_EXT));
    if (busy) rdata_o = ext_rdata_i;
    else begin
      unique case (region)
        RG_ROM:  rdata_o = rom_rdata_i;
        RG_RAM:  rdata_o = ram_rdata_i;
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/pfr_sva.sv
module pfr_sva #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int WW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ready_i,
  input logic [WW-1:0] wait_i,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] wdata_o,
  input logic          done_o,
  input logic          ram_we_o,
  input logic          ext_rd_o,
  input logic          ext_wr_o
);
  logic          ext_any, ext_prev_q, rise;
  logic [WW-1:0] prev_wait_q, wait_q, wait_now;
  logic [15:0]   age_q, age_now;

  assign ext_any  = ext_rd_o || ext_wr_o;
  assign rise     = ext_any && !ext_prev_q;
  assign wait_now = rise ? prev_wait_q : wait_q;
  assign age_now  = rise ? 16'd1 : ((age_q == 16'hFFFF) ? age_q : age_q + 16'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_prev_q  <= 1'b0;
      prev_wait_q <= '0;
      wait_q      <= '0;
      age_q       <= '0;
    end else begin
      ext_prev_q  <= ext_any;
      prev_wait_q <= wait_i;
      wait_q      <= wait_now;
      age_q       <= age_now;
    end
  end

  a_r3_strobe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_any && !done_o) |=> ext_any);
  a_r3_strobe_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_any && done_o) |=> !ext_any);
  a_r4_min_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_any && done_o) |-> (age_now > 16'(wait_now)));
  a_r5_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_any && !ready_i) |-> !done_o);
  a_r7_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ext_rd_o && ext_wr_o));
  a_r7_ram_we_done: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_o |-> (done_o && !ext_any));
  a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_any && !done_o) |=> ($stable(mem_addr_o) && $stable(wdata_o)));
endmodule

bind prog_fetch_router pfr_sva #(.AW(AW), .DW(DW), .WW(WW)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .ready_i    (ready_i),
  .wait_i     (wait_i),
  .mem_addr_o (mem_addr_o),
  .wdata_o    (wdata_o),
  .done_o     (done_o),
  .ram_we_o   (ram_we_o),
  .ext_rd_o   (ext_rd_o),
  .ext_wr_o   (ext_wr_o)
);

// File: tb/prog_fetch_router_tb_top.sv
module prog_fetch_router_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, ready = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [2:0]  rc = 3'd3, mc = 3'd3, wt = '0;
  logic        roff = 1'b0, moff = 1'b0;
  logic [7:0]  rom_d, ram_d, ext_d, rdata, wdata_o;
  logic [15:0] mem_addr;
  logic        done, ram_we, ext_rd, ext_wr;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  assign rom_d = addr[7:0] ^ 8'h11;
  assign ram_d = addr[7:0] ^ 8'h22;
  assign ext_d = mem_addr[7:0] ^ 8'h5A;

  prog_fetch_router dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rom_code_i(rc), .rom_off_i(roff), .ram_code_i(mc),
    .ram_off_i(moff), .wait_i(wt), .ready_i(ready), .rom_rdata_i(rom_d),
    .ram_rdata_i(ram_d), .ext_rdata_i(ext_d), .mem_addr_o(mem_addr),
    .wdata_o(wdata_o), .rdata_o(rdata), .done_o(done), .ram_we_o(ram_we),
    .ext_rd_o(ext_rd), .ext_wr_o(ext_wr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int rsize(input logic [2:0] c);
    return 1 << (int'(c) + 7);
  endfunction

  // 0 = ROM, 1 = RAM, 2 = off-chip
  function automatic int exp_region(input logic [15:0] a);
    bit rp = !(roff && rc == 0);
    bit mp = !(moff && mc == 0);
    if (rp && int'(a) < rsize(rc)) return 0;
    if (mp && int'(a) >= 65536 - rsize(mc)) return 1;
    return 2;
  endfunction

  task automatic access(input logic [15:0] a, input bit w, input logic [2:0] wc, input int lag);
    int rg = exp_region(a);
    int expk = ((int'(wc) > lag) ? int'(wc) : lag) + 1;
    int got = 0;
    logic [7:0] wd = 8'($urandom);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = wd; wt = wc; ready = 1'b1;
    #1;
    if (rg == 0) begin
      chk(done === 1'b1, "R1 rom done", done, 1);
      if (w) chk(ram_we === 1'b0 && !ext_wr, "R7 rom write no strobe", ram_we, 0);
      else   chk(rdata === rom_d, "R1 rom data", rdata, rom_d);
    end else if (rg == 1) begin
      chk(done === 1'b1, "R2 ram done", done, 1);
      if (w) chk(ram_we === 1'b1, "R7 ram write enable", ram_we, 1);
      else   chk(rdata === ram_d, "R2 ram data", rdata, ram_d);
    end else begin
      chk(done === 1'b0 && !ext_rd && !ext_wr && !ram_we, "R3 no zero-wait", done, 0);
      @(negedge clk);
      for (int k = 1; k <= expk + 3; k++) begin
        req   = (k == 1 && expk > 1);
        we    = 1'b1;
        addr  = 16'hFFFF;
        wdata = ~wd;
        ready = (k > lag);
        #1;
        if (req) chk(ram_we === 1'b0, "R8 overlapping request ignored", ram_we, 0);
        chk(mem_addr === a && wdata_o === wd, "R8 address held", mem_addr, a);
        chk(w ? (ext_wr && !ext_rd) : (ext_rd && !ext_wr), "R3 R7 strobe kind",
            {ext_rd, ext_wr}, w ? 1 : 2);
        if (done) begin
          got = k;
          if (!w) chk(rdata === (a[7:0] ^ 8'h5A), "R3 ext data", rdata, a[7:0] ^ 8'h5A);
          break;
        end
        @(negedge clk);
      end
      chk(got == expk, "R4 R5 done cycle", got, expk);
      @(negedge clk);
      req = 1'b0; ready = 1'b1;
      #1;
      chk(!ext_rd && !ext_wr && !done, "R3 R5 strobe release single pulse", {ext_rd, ext_wr, done}, 0);
    end
    @(negedge clk);
    req = 1'b0;
  endtask

  function automatic logic [15:0] pick_addr();
    int s = $urandom % 7;
    case (s)
      0: return 16'($urandom);
      1: return 16'(rsize(rc) - 1);
      2: return 16'(rsize(rc));
      3: return 16'(65536 - rsize(mc));
      4: return 16'(65535 - rsize(mc));
      5: return 16'hFFFF;
      default: return 16'h0000;
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24680));
    // R9: request held during reset
    req = 1'b1; addr = 16'h0000;
    repeat (3) @(negedge clk);
    #1 chk(!done && !ram_we && !ext_rd && !ext_wr, "R9 reset quiet", done, 0);
    @(negedge clk); rst_n = 1'b1; req = 1'b0;
    repeat (3) @(negedge clk);
    #1 chk(!done && !ram_we && !ext_rd && !ext_wr, "R9 idle after reset", done, 0);

    // directed corners
    rc = 3'd0; roff = 1'b1; mc = 3'd2; moff = 1'b0;
    access(16'h0000, 1'b0, 3'd2, 0);     // R6 absent ROM -> off-chip
    rc = 3'd3; roff = 1'b1;
    access(16'h0000, 1'b0, 3'd0, 0);     // R6 flag ignored, ROM
    mc = 3'd0; moff = 1'b1;
    access(16'hFFFF, 1'b1, 3'd1, 0);     // R6 absent RAM, R7 off-chip write
    moff = 1'b0;
    access(16'hFF80, 1'b1, 3'd0, 0);     // R7 ram write at base
    access(16'h007F, 1'b1, 3'd0, 0);     // R7 rom write
    access(16'h4000, 1'b0, 3'd5, 8);     // R5 ready stretch past wait
    access(16'h4001, 1'b0, 3'd0, 0);     // R4 zero wait off-chip

    for (int i = 0; i < 400; i++) begin
      rc = 3'($urandom); mc = 3'($urandom);
      roff = ($urandom % 4) == 0; moff = ($urandom % 4) == 0;
      access(pick_addr(), ($urandom % 3) == 0, 3'($urandom % 6), int'($urandom % 9));
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule